// File: doc/BRIEF.md
# Decode Operand Bypass Selector

This block is the combinational bypass network for the decode stage of a five-stage, in-order pipeline with eight 32-bit architectural registers. Decode needs two source operands, A and B. A newer value for either register may already exist in the execute, memory or writeback stage. When it does, this block returns that value instead of the stale register-file read data.

Each later stage carries two tagged results. One is the ALU result; ALU operations and register or immediate moves produce their result on this path. The other is the loaded value, and loads write their destination only through this path. That gives six bypass candidates per operand.

Priority goes to the youngest producer: execute, then memory, then writeback. Within one stage, the ALU result is checked before the loaded value. Register ID 4'hF means "no register". A load still in execute has no data yet. Its load tag must be held at 4'hF until the data exists. Catching that case is the job of a separate stall mechanism.

Top module: `decode_bypass_sel`

## Requirements
- R1: When a source ID is 4'hF, that operand is 32'h0, whatever the destination tags and the register-file data are.
- R2: When a source ID is not 4'hF and matches no candidate tag, the operand equals its register-file read value.
- R3: A destination tag of 4'hF never matches, not even a source ID of 4'hF. With every tag at 4'hF, a valid source returns its register-file value.
- R4: A match on the execute-stage ALU tag returns the execute ALU value, even when every other candidate also matches.
- R5: Within one stage, when both tags match, the ALU result is returned. The loaded value is returned when only the load tag matches.
- R6: When execute has no match, a memory-stage match wins over a writeback-stage match.
- R7: A writeback-stage match is forwarded over the register-file value in the same cycle.
- R8: Operands A and B are selected independently. Each uses its own source ID and its own register-file value over the shared candidates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a_id | input | 4 | Source register ID for operand A (4'hF = none) |
| src_b_id | input | 4 | Source register ID for operand B (4'hF = none) |
| ex_alu_dst | input | 4 | Execute stage ALU result destination tag |
| ex_alu_val | input | 32 | Execute stage ALU result |
| ex_ld_dst | input | 4 | Execute stage load destination tag |
| ex_ld_val | input | 32 | Execute stage loaded value |
| mem_alu_dst | input | 4 | Memory stage ALU result destination tag |
| mem_alu_val | input | 32 | Memory stage ALU result |
| mem_ld_dst | input | 4 | Memory stage load destination tag |
| mem_ld_val | input | 32 | Memory stage loaded value |
| wb_alu_dst | input | 4 | Writeback stage ALU result destination tag |
| wb_alu_val | input | 32 | Writeback stage ALU result |
| wb_ld_dst | input | 4 | Writeback stage load destination tag |
| wb_ld_val | input | 32 | Writeback stage loaded value |
| rf_a_val | input | 32 | Register-file read data for operand A |
| rf_b_val | input | 32 | Register-file read data for operand B |
| opnd_a | output | 32 | Forwarded operand A |
| opnd_b | output | 32 | Forwarded operand B |

## Verification
The hardest cases are the ones where several candidates name the same register at once. Only the winner shows at the output, so a wrong priority order stays hidden unless many tags collide. The stimulus handles this with a sweep. For every source ID it runs through all 64 subsets of the six tags, setting each chosen tag to the source and each other tag to a different register. Operand B is given a different source over the same tags, so that one set of tags produces different winners on A and B. All-4'hF tags are also applied against a 4'hF source, to show that "none" never matches "none".

// File: rtl/dbyp_pkg.sv
package dbyp_pkg;

  localparam int REG_ID_W = 4;
  localparam logic [REG_ID_W-1:0] REG_NONE = 4'hF;

  // Candidate order is also the priority order: index 0 wins.
  localparam int NUM_STAGES     = 3;
  localparam int PORTS_PER_STG  = 2;
  localparam int NUM_CAND       = NUM_STAGES * PORTS_PER_STG;

  typedef enum int {
    CAND_EX_ALU  = 0,
    CAND_EX_LD   = 1,
    CAND_MEM_ALU = 2,
    CAND_MEM_LD  = 3,
    CAND_WB_ALU  = 4,
    CAND_WB_LD   = 5
  } cand_e;

  typedef logic [REG_ID_W-1:0] reg_id_t;

  // A tag matches only when both IDs name a real register and are equal.
  function automatic logic id_hit(input reg_id_t src, input reg_id_t dst);
    return (src != REG_NONE) && (dst != REG_NONE) && (src == dst);
  endfunction

  // Index of the first set bit, or NUM_CAND when none is set.
  function automatic int first_hit(input logic [NUM_CAND-1:0] hits);
    int idx;
    idx = NUM_CAND;
    for (int i = NUM_CAND - 1; i >= 0; i--) begin
      if (hits[i]) idx = i;
    end
    return idx;
  endfunction

endpackage

// File: rtl/fwd_tag_match.sv
module fwd_tag_match
  import dbyp_pkg::*;
#(
  parameter int N = NUM_CAND
) (
  input  reg_id_t              src_id,
  input  reg_id_t [N-1:0]      dst_id,
  output logic    [N-1:0]      hit
);

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit[g] = id_hit(src_id, dst_id[g]);
  end

endmodule

// File: rtl/fwd_prio_mux.sv
module fwd_prio_mux #(
  parameter int N      = 6,
  parameter int DATA_W = 32
) (
  input  logic [N-1:0]             hit,
  input  logic [N-1:0][DATA_W-1:0] cand_val,
  input  logic [DATA_W-1:0]        fallback,
  input  logic                     src_none,
  output logic [DATA_W-1:0]        out_val
);

  always_comb begin
    out_val = src_none ? '0 : fallback;
    // Walk from lowest priority to highest so the youngest match is last.
    for (int i = N - 1; i >= 0; i--) begin
      if (hit[i]) out_val = cand_val[i];
    end
  end

endmodule

// File: rtl/fwd_operand_path.sv
module fwd_operand_path
  import dbyp_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  reg_id_t                         src_id,
  input  reg_id_t [NUM_CAND-1:0]          cand_dst,
  input  logic    [NUM_CAND-1:0][DATA_W-1:0] cand_val,
  input  logic    [DATA_W-1:0]            rf_val,
  output logic    [NUM_CAND-1:0]          hit,
  output logic    [DATA_W-1:0]            opnd
);

  logic src_none;
  assign src_none = (src_id == REG_NONE);

  fwd_tag_match #(.N(NUM_CAND)) u_match (
    .src_id (src_id),
    .dst_id (cand_dst),
    .hit    (hit)
  );

  fwd_prio_mux #(.N(NUM_CAND), .DATA_W(DATA_W)) u_mux (
    .hit      (hit),
    .cand_val (cand_val),
    .fallback (rf_val),
    .src_none (src_none),
    .out_val  (opnd)
  );

endmodule

// File: rtl/decode_bypass_sel.sv
module decode_bypass_sel
  import dbyp_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [3:0]        src_a_id,
  input  logic [3:0]        src_b_id,
  input  logic [3:0]        ex_alu_dst,
  input  logic [DATA_W-1:0] ex_alu_val,
  input  logic [3:0]        ex_ld_dst,
  input  logic [DATA_W-1:0] ex_ld_val,
  input  logic [3:0]        mem_alu_dst,
  input  logic [DATA_W-1:0] mem_alu_val,
  input  logic [3:0]        mem_ld_dst,
  input  logic [DATA_W-1:0] mem_ld_val,
  input  logic [3:0]        wb_alu_dst,
  input  logic [DATA_W-1:0] wb_alu_val,
  input  logic [3:0]        wb_ld_dst,
  input  logic [DATA_W-1:0] wb_ld_val,
  input  logic [DATA_W-1:0] rf_a_val,
  input  logic [DATA_W-1:0] rf_b_val,
  output logic [DATA_W-1:0] opnd_a,
  output logic [DATA_W-1:0] opnd_b
);

  localparam int NUM_OPND = 2;

  reg_id_t [NUM_CAND-1:0]              cand_dst;
  logic    [NUM_CAND-1:0][DATA_W-1:0]  cand_val;

  assign cand_dst[CAND_EX_ALU]  = ex_alu_dst;
  assign cand_dst[CAND_EX_LD]   = ex_ld_dst;
  assign cand_dst[CAND_MEM_ALU] = mem_alu_dst;
  assign cand_dst[CAND_MEM_LD]  = mem_ld_dst;
  assign cand_dst[CAND_WB_ALU]  = wb_alu_dst;
  assign cand_dst[CAND_WB_LD]   = wb_ld_dst;

  assign cand_val[CAND_EX_ALU]  = ex_alu_val;
  assign cand_val[CAND_EX_LD]   = ex_ld_val;
  assign cand_val[CAND_MEM_ALU] = mem_alu_val;
  assign cand_val[CAND_MEM_LD]  = mem_ld_val;
  assign cand_val[CAND_WB_ALU]  = wb_alu_val;
  assign cand_val[CAND_WB_LD]   = wb_ld_val;

  reg_id_t [NUM_OPND-1:0]                 src_id;
  logic    [NUM_OPND-1:0][DATA_W-1:0]     rf_val;
  logic    [NUM_OPND-1:0][DATA_W-1:0]     opnd;
  logic    [NUM_OPND-1:0][NUM_CAND-1:0]   hit_vec;

  assign src_id[0] = src_a_id;
  assign src_id[1] = src_b_id;
  assign rf_val[0] = rf_a_val;
  assign rf_val[1] = rf_b_val;

  for (genvar op = 0; op < NUM_OPND; op++) begin : g_opnd
    fwd_operand_path #(.DATA_W(DATA_W)) u_path (
      .src_id   (src_id[op]),
      .cand_dst (cand_dst),
      .cand_val (cand_val),
      .rf_val   (rf_val[op]),
      .hit      (hit_vec[op]),
      .opnd     (opnd[op])
    );
  end

  // Named match events for the checker.
  logic [NUM_CAND-1:0] hit_a;
  logic [NUM_CAND-1:0] hit_b;
  assign hit_a = hit_vec[0];
  assign hit_b = hit_vec[1];

  assign opnd_a = opnd[0];
  assign opnd_b = opnd[1];

endmodule

// File: rtl/decode_bypass_sel_chk.sv
module decode_bypass_sel_chk
  import dbyp_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic [3:0]          src_a_id,
  input logic [3:0]          src_b_id,
  input logic [3:0]          ex_alu_dst,
  input logic [DATA_W-1:0]   ex_alu_val,
  input logic [DATA_W-1:0]   mem_alu_val,
  input logic [DATA_W-1:0]   mem_ld_val,
  input logic [DATA_W-1:0]   wb_alu_val,
  input logic [DATA_W-1:0]   wb_ld_val,
  input logic [DATA_W-1:0]   rf_a_val,
  input logic [DATA_W-1:0]   rf_b_val,
  input logic [DATA_W-1:0]   opnd_a,
  input logic [DATA_W-1:0]   opnd_b,
  input logic [NUM_CAND-1:0] hit_a,
  input logic [NUM_CAND-1:0] hit_b
);

  always_comb begin
    if (src_a_id == REG_NONE) AST_A_NONE_ZERO: assert (opnd_a == '0);   // R1
    if (src_b_id == REG_NONE) AST_B_NONE_ZERO: assert (opnd_b == '0);   // R1
    if (src_a_id == REG_NONE) AST_A_NONE_NOHIT: assert (hit_a == '0);   // R3
    if (ex_alu_dst == REG_NONE) AST_EX_NONE_NOHIT: assert (!hit_a[CAND_EX_ALU]); // R3
    if (hit_a == '0 && src_a_id != REG_NONE)
      AST_A_MISS_RF: assert (opnd_a == rf_a_val);                       // R2
    if (hit_b == '0 && src_b_id != REG_NONE)
      AST_B_MISS_RF: assert (opnd_b == rf_b_val);                       // R8
    if (hit_a[CAND_EX_ALU]) AST_A_EX_WINS: assert (opnd_a == ex_alu_val); // R4
    if (hit_a[CAND_MEM_ALU] && hit_a[CAND_MEM_LD] && hit_a[1:0] == '0)
      AST_A_MEM_ALU_FIRST: assert (opnd_a == mem_alu_val);              // R5
    if (hit_a[3:2] != '0 && hit_a[1:0] == '0)
      AST_A_MEM_OVER_WB: assert (opnd_a == mem_alu_val || opnd_a == mem_ld_val); // R6
    if (hit_a[5:4] != '0 && hit_a[3:0] == '0)
      AST_A_WB_FWD: assert (opnd_a == wb_alu_val || opnd_a == wb_ld_val); // R7
  end

endmodule

bind decode_bypass_sel decode_bypass_sel_chk #(.DATA_W(DATA_W)) u_chk (
  .src_a_id    (src_a_id),
  .src_b_id    (src_b_id),
  .ex_alu_dst  (ex_alu_dst),
  .ex_alu_val  (ex_alu_val),
  .mem_alu_val (mem_alu_val),
  .mem_ld_val  (mem_ld_val),
  .wb_alu_val  (wb_alu_val),
  .wb_ld_val   (wb_ld_val),
  .rf_a_val    (rf_a_val),
  .rf_b_val    (rf_b_val),
  .opnd_a      (opnd_a),
  .opnd_b      (opnd_b),
  .hit_a       (hit_a),
  .hit_b       (hit_b)
);

// File: tb/decode_bypass_sel_tb_top.sv
module decode_bypass_sel_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NC = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [3:0]  src_a_id, src_b_id;
  logic [3:0]  dst [NC];
  logic [31:0] val [NC];
  logic [31:0] rf_a_val, rf_b_val;
  logic [31:0] opnd_a, opnd_b;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  decode_bypass_sel dut_i (
    .src_a_id   (src_a_id),   .src_b_id   (src_b_id),
    .ex_alu_dst (dst[0]),     .ex_alu_val (val[0]),
    .ex_ld_dst  (dst[1]),     .ex_ld_val  (val[1]),
    .mem_alu_dst(dst[2]),     .mem_alu_val(val[2]),
    .mem_ld_dst (dst[3]),     .mem_ld_val (val[3]),
    .wb_alu_dst (dst[4]),     .wb_alu_val (val[4]),
    .wb_ld_dst  (dst[5]),     .wb_ld_val  (val[5]),
    .rf_a_val   (rf_a_val),   .rf_b_val   (rf_b_val),
    .opnd_a     (opnd_a),     .opnd_b     (opnd_b)
  );

  // Expected operand: first candidate (youngest, ALU before load) whose
  // tag equals a real source register; else register file, or zero for none.
  function automatic logic [31:0] model(input logic [3:0] s, input logic [31:0] rf,
                                        output int win);
    win = NC;
    for (int k = NC - 1; k >= 0; k--)
      if (s != 4'hF && dst[k] != 4'hF && dst[k] == s) win = k;
    if (win < NC) return val[win];
    return (s == 4'hF) ? 32'h0 : rf;
  endfunction

  function automatic string tag_of(input logic [3:0] s, input int win);
    if (s == 4'hF) return "R1";
    if (win == NC) return "R2";
    if (win == 0) return "R4";
    if (win % 2 == 1) return "R5";
    if (win == 2) return "R6";
    return "R7";
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic settle_and_check(input string force_tag);
    int wa, wb;
    logic [31:0] ea, eb;
    #(CLK_PERIOD/4);
    ea = model(src_a_id, rf_a_val, wa);
    eb = model(src_b_id, rf_b_val, wb);
    check(force_tag != "" ? force_tag : tag_of(src_a_id, wa), opnd_a, ea);
    check("R8", opnd_b, eb);
  endtask

  task automatic set_vals(input logic [3:0] s);
    for (int k = 0; k < NC; k++) val[k] = (32'h1111_1111 * (k + 1)) ^ {28'h0, s};
    rf_a_val = 32'hDEAD_0000 | {28'h0, s};
    rf_b_val = 32'hBEEF_0000 | {28'h0, s};
  endtask

  initial begin
    src_a_id = 4'hF; src_b_id = 4'hF;
    for (int k = 0; k < NC; k++) dst[k] = 4'hF;
    set_vals(4'h0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    // Idle state: no sources, no tags -> both operands zero (R1)
    @(negedge clk);
    settle_and_check("R1");

    // All tags none, none source: none never matches none (R3)
    @(negedge clk);
    src_a_id = 4'hF; src_b_id = 4'h2;
    settle_and_check("R3");

    // All tags none, every valid source returns register file (R3)
    for (int s = 0; s < 8; s++) begin
      @(negedge clk);
      src_a_id = s[3:0]; src_b_id = s[3:0] ^ 4'h1;
      set_vals(s[3:0]);
      settle_and_check("R3");
    end

    // Sweep every source ID against every subset of matching tags
    for (int s = 0; s < 16; s++) begin
      for (int p = 0; p < 64; p++) begin
        @(negedge clk);
        src_a_id = s[3:0];
        src_b_id = (s == 15) ? 4'h6 : (s[3:0] ^ 4'h4);
        set_vals(s[3:0]);
        for (int k = 0; k < NC; k++)
          dst[k] = p[k] ? s[3:0] : ((s == 15) ? 4'h3 : ((s[3:0] + 4'h1) & 4'h7));
        settle_and_check("");
      end
    end

    // Directed: writeback load alone over register file (R7)
    @(negedge clk);
    for (int k = 0; k < NC; k++) dst[k] = 4'hF;
    dst[5] = 4'h5; src_a_id = 4'h5; src_b_id = 4'h0; set_vals(4'h5);
    settle_and_check("R7");

    // Directed: all six match, execute ALU wins (R4)
    @(negedge clk);
    for (int k = 0; k < NC; k++) dst[k] = 4'h2;
    src_a_id = 4'h2; src_b_id = 4'h2; set_vals(4'h2);
    settle_and_check("R4");

    done = 1'b1;
  end

  initial begin : watchdog
    int cyc;
    cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule